// File: doc/BRIEF.md
# Seven-Twiddle Multiplierless Constant Rotator

This block rotates one complex fixed-point sample by a twiddle factor chosen from a fixed set of seven: 1, W8, -j, -j·W8, W16^1, W16^3 and -W16^1. Here W_N^k = exp(-j·2πk/N). It contains no general-purpose multiplier. Two identical shift-add units, one per input component, each form the three constant products of their component with cos(π/8), sin(π/8) and cos(π/4). A small decoder turns the 3-bit twiddle index into a control word. A combiner then picks, adds, subtracts and negates the partial products to form the rotated real and imaginary parts.

The block is meant to sit between the butterfly stages of a pipelined transform. Each cycle the caller presents a sample and a twiddle index with a valid flag. The rotated sample appears one clock later, held in a single output register. The output width equals the input width. Results that do not fit are clamped. Scheduling the twiddle index across a frame is the caller's job.

Top module: `twiddle_rotor7`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `out_re` and `out_im` become 0 on that edge.
- R2: `out_valid` equals `in_valid` of the previous clock edge, and each accepted sample produces exactly one output one cycle later.
- R3: When `in_valid` is low, `out_re` and `out_im` keep their previous values.
- R4: Twiddle codes 0 (unity) and 7 (spare, treated as unity) pass the input through unchanged: out = (re, im).
- R5: Code 2 (-j) gives out_re = im and out_im = -re exactly, with +512 clamped to 511.
- R6: Code 4 (W16^1) gives out_re ≈ re·cos(π/8) + im·sin(π/8) and out_im ≈ im·cos(π/8) - re·sin(π/8), within 3 LSB.
- R7: Code 5 (W16^3) gives out_re ≈ re·sin(π/8) + im·cos(π/8) and out_im ≈ im·sin(π/8) - re·cos(π/8), within 3 LSB.
- R8: Code 6 (-W16^1) gives the negation of the code 4 result, within 3 LSB.
- R9: Code 1 (W8) gives out_re ≈ cos(π/4)·(re + im) and out_im ≈ cos(π/4)·(im - re), within 3 LSB.
- R10: Code 3 (-j·W8) gives out_re ≈ cos(π/4)·(im - re) and out_im ≈ -cos(π/4)·(re + im), within 3 LSB.
- R11: A result outside the signed 10-bit range clamps to -512 or 511 and never wraps. The constant products use the 9-fraction-bit codes 473 (cos π/8), 195 (sin π/8) and 362 (cos π/4), with each product floored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample is valid this cycle |
| in_re | input | 10 | Real part of input, two's complement |
| in_im | input | 10 | Imaginary part of input, two's complement |
| in_tw | input | 3 | Twiddle code: 0=1, 1=W8, 2=-j, 3=-jW8, 4=W16^1, 5=W16^3, 6=-W16^1, 7=1 |
| out_valid | output | 1 | Output sample valid |
| out_re | output | 10 | Real part of rotated sample |
| out_im | output | 10 | Imaginary part of rotated sample |

## Verification
The bench drives the four full-scale corner points through every twiddle code. At these points the sum of two products exceeds the 10-bit range. A combiner without clamping would wrap to the opposite sign, and a -j path would turn -512 into -512 instead of 511. Small values such as ±1 and 0 expose sign-extension and floor mistakes in the shift-add units, which would show up as errors of whole powers of two. Random samples over all codes catch a swapped cos/sin pair or a missed negation, because the result would land far outside the tolerance. Idle gaps between samples catch an output register that updates without a valid input.

// File: rtl/twrot_pkg.sv
package twrot_pkg;

    // Twiddle index encoding seen at the block boundary
    typedef enum logic [2:0] {
        TW_ONE       = 3'd0,
        TW_W8        = 3'd1,
        TW_NEGJ      = 3'd2,
        TW_NEGJ_W8   = 3'd3,
        TW_W16_1     = 3'd4,
        TW_W16_3     = 3'd5,
        TW_NEG_W16_1 = 3'd6,
        TW_SPARE     = 3'd7
    } tw_code_e;

    // Which constant pair (k1, k2) feeds the rotation core
    typedef enum logic [1:0] {
        KP_C8_S8 = 2'd0,
        KP_S8_C8 = 2'd1,
        KP_C4_C4 = 2'd2
    } kpair_e;

    // Operation applied after the core
    typedef enum logic [1:0] {
        PO_NONE = 2'd0,
        PO_NEG  = 2'd1,
        PO_NEGJ = 2'd2
    } post_e;

    typedef struct packed {
        logic   use_prod;
        kpair_e kpair;
        post_e  post;
    } rot_ctrl_t;

    // Fraction bits of the constant codes (codes 473, 195, 362)
    localparam int COEF_FRAC = 9;

endpackage

// File: rtl/twrot_const_mul.sv
module twrot_const_mul
    import twrot_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic signed [DATA_W-1:0] y,
    output logic signed [DATA_W:0]   p_c8,
    output logic signed [DATA_W:0]   p_s8,
    output logic signed [DATA_W:0]   p_c4
);
    localparam int ACC_W = DATA_W + COEF_FRAC + 1;

    logic signed [ACC_W-1:0] y_x;
    logic signed [ACC_W-1:0] y3;
    logic signed [ACC_W-1:0] acc_c8;
    logic signed [ACC_W-1:0] acc_s8;
    logic signed [ACC_W-1:0] acc_c4;

    always_comb begin
        y_x    = ACC_W'(y);
        // shared term 3y
        y3     = y_x + (y_x <<< 1);
        // 195 = 3*64 + 3
        acc_s8 = (y3 <<< 6) + y3;
        // 473 = 3*128 + 3*8 + 64 + 1
        acc_c8 = (y3 <<< 7) + (y3 <<< 3) + (y_x <<< 6) + y_x;
        // 362 = 256 + 3*32 + 8 + 2
        acc_c4 = (y_x <<< 8) + (y3 <<< 5) + (y_x <<< 3) + (y_x <<< 1);
    end

    // floor division by 2^FRAC, kept to DATA_W+1 bits
    assign p_c8 = (DATA_W+1)'(acc_c8 >>> COEF_FRAC);
    assign p_s8 = (DATA_W+1)'(acc_s8 >>> COEF_FRAC);
    assign p_c4 = (DATA_W+1)'(acc_c4 >>> COEF_FRAC);

endmodule

// File: rtl/twrot_decode.sv
module twrot_decode
    import twrot_pkg::*;
(
    input  tw_code_e  tw,
    output rot_ctrl_t ctrl
);
    always_comb begin
        unique case (tw)
            TW_W8:        ctrl = '{use_prod: 1'b1, kpair: KP_C4_C4, post: PO_NONE};
            TW_NEGJ:      ctrl = '{use_prod: 1'b0, kpair: KP_C8_S8, post: PO_NEGJ};
            TW_NEGJ_W8:   ctrl = '{use_prod: 1'b1, kpair: KP_C4_C4, post: PO_NEGJ};
            TW_W16_1:     ctrl = '{use_prod: 1'b1, kpair: KP_C8_S8, post: PO_NONE};
            TW_W16_3:     ctrl = '{use_prod: 1'b1, kpair: KP_S8_C8, post: PO_NONE};
            TW_NEG_W16_1: ctrl = '{use_prod: 1'b1, kpair: KP_C8_S8, post: PO_NEG};
            default:      ctrl = '{use_prod: 1'b0, kpair: KP_C8_S8, post: PO_NONE};
        endcase
    end
endmodule

// File: rtl/twrot_combine.sv
module twrot_combine
    import twrot_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  rot_ctrl_t                ctrl,
    input  logic signed [DATA_W-1:0] a,
    input  logic signed [DATA_W-1:0] b,
    input  logic signed [DATA_W:0]   a_c8,
    input  logic signed [DATA_W:0]   a_s8,
    input  logic signed [DATA_W:0]   a_c4,
    input  logic signed [DATA_W:0]   b_c8,
    input  logic signed [DATA_W:0]   b_s8,
    input  logic signed [DATA_W:0]   b_c4,
    output logic signed [DATA_W-1:0] z_re,
    output logic signed [DATA_W-1:0] z_im
);
    localparam int SUM_W = DATA_W + 2;
    localparam logic signed [SUM_W-1:0] HI_V = SUM_W'((1 <<< (DATA_W-1)) - 1);
    localparam logic signed [SUM_W-1:0] LO_V = SUM_W'(-(1 <<< (DATA_W-1)));

    logic signed [DATA_W:0]  a_k1, a_k2, b_k1, b_k2;
    logic signed [SUM_W-1:0] base_re, base_im;
    logic signed [SUM_W-1:0] post_re, post_im;

    function automatic logic signed [DATA_W-1:0] clamp(input logic signed [SUM_W-1:0] v);
        if (v > HI_V)      return DATA_W'(HI_V);
        else if (v < LO_V) return DATA_W'(LO_V);
        else               return DATA_W'(v);
    endfunction

    always_comb begin
        unique case (ctrl.kpair)
            KP_S8_C8: begin
                a_k1 = a_s8; a_k2 = a_c8; b_k1 = b_s8; b_k2 = b_c8;
            end
            KP_C4_C4: begin
                a_k1 = a_c4; a_k2 = a_c4; b_k1 = b_c4; b_k2 = b_c4;
            end
            default: begin
                a_k1 = a_c8; a_k2 = a_s8; b_k1 = b_c8; b_k2 = b_s8;
            end
        endcase

        // (a + jb) * (k1 - j*k2)
        if (ctrl.use_prod) begin
            base_re = SUM_W'(a_k1) + SUM_W'(b_k2);
            base_im = SUM_W'(b_k1) - SUM_W'(a_k2);
        end else begin
            base_re = SUM_W'(a);
            base_im = SUM_W'(b);
        end

        unique case (ctrl.post)
            PO_NEG: begin
                post_re = -base_re;
                post_im = -base_im;
            end
            PO_NEGJ: begin
                post_re = base_im;
                post_im = -base_re;
            end
            default: begin
                post_re = base_re;
                post_im = base_im;
            end
        endcase

        z_re = clamp(post_re);
        z_im = clamp(post_im);
    end
endmodule

// File: rtl/twiddle_rotor7.sv
module twiddle_rotor7
    import twrot_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_re,
    input  logic signed [DATA_W-1:0] in_im,
    input  logic [2:0]               in_tw,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_re,
    output logic signed [DATA_W-1:0] out_im
);
    localparam int N_COMP = 2;

    logic signed [DATA_W-1:0] comp   [N_COMP];
    logic signed [DATA_W:0]   prod_c8[N_COMP];
    logic signed [DATA_W:0]   prod_s8[N_COMP];
    logic signed [DATA_W:0]   prod_c4[N_COMP];

    rot_ctrl_t                ctrl;
    logic signed [DATA_W-1:0] z_re, z_im;

    assign comp[0] = in_re;
    assign comp[1] = in_im;

    for (genvar g = 0; g < N_COMP; g++) begin : g_cmul
        twrot_const_mul #(.DATA_W(DATA_W)) u_cmul (
            .y    (comp[g]),
            .p_c8 (prod_c8[g]),
            .p_s8 (prod_s8[g]),
            .p_c4 (prod_c4[g])
        );
    end

    twrot_decode u_dec (
        .tw   (tw_code_e'(in_tw)),
        .ctrl (ctrl)
    );

    twrot_combine #(.DATA_W(DATA_W)) u_comb (
        .ctrl (ctrl),
        .a    (in_re),
        .b    (in_im),
        .a_c8 (prod_c8[0]),
        .a_s8 (prod_s8[0]),
        .a_c4 (prod_c4[0]),
        .b_c8 (prod_c8[1]),
        .b_s8 (prod_s8[1]),
        .b_c4 (prod_c4[1]),
        .z_re (z_re),
        .z_im (z_im)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_re <= z_re;
                out_im <= z_im;
            end
        end
    end

endmodule

// File: rtl/twiddle_rotor7_chk.sv
module twiddle_rotor7_chk #(
    parameter int DATA_W = 10
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic signed [DATA_W-1:0] in_re,
    input logic signed [DATA_W-1:0] in_im,
    input logic [2:0]               in_tw,
    input logic                     out_valid,
    input logic signed [DATA_W-1:0] out_re,
    input logic signed [DATA_W-1:0] out_im
);
    localparam logic signed [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R2
    a_r2_valid_rise: assert property (@(posedge clk) disable iff (rst || !armed)
        in_valid |=> out_valid);
    a_r2_valid_idle: assert property (@(posedge clk) disable iff (rst || !armed)
        !in_valid |=> !out_valid);

    // R3
    a_r3_hold: assert property (@(posedge clk) disable iff (rst || !armed)
        !in_valid |=> ($stable(out_re) && $stable(out_im)));

    // R4
    a_r4_unity: assert property (@(posedge clk) disable iff (rst || !armed)
        (in_valid && (in_tw == 3'd0 || in_tw == 3'd7))
        |=> (out_re == $past(in_re) && out_im == $past(in_im)));

    // R5
    a_r5_negj_re: assert property (@(posedge clk) disable iff (rst || !armed)
        (in_valid && in_tw == 3'd2) |=> (out_re == $past(in_im)));
    a_r5_negj_im: assert property (@(posedge clk) disable iff (rst || !armed)
        (in_valid && in_tw == 3'd2 && in_re != MIN_V) |=> (out_im == -$past(in_re)));

    // R11
    a_r11_negj_clamp: assert property (@(posedge clk) disable iff (rst || !armed)
        (in_valid && in_tw == 3'd2 && in_re == MIN_V) |=> (out_im == ~MIN_V));

endmodule

bind twiddle_rotor7 twiddle_rotor7_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_re     (in_re),
    .in_im     (in_im),
    .in_tw     (in_tw),
    .out_valid (out_valid),
    .out_re    (out_re),
    .out_im    (out_im)
);

// File: tb/twiddle_rotor7_tb.sv
`timescale 1ns/1ps
module twiddle_rotor7_tb;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic signed [9:0] in_re = '0;
    logic signed [9:0] in_im = '0;
    logic [2:0]        in_tw = '0;
    logic              out_valid;
    logic signed [9:0] out_re;
    logic signed [9:0] out_im;

    always #2 clk = ~clk;

    twiddle_rotor7 u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_re     (in_re),
        .in_im     (in_im),
        .in_tw     (in_tw),
        .out_valid (out_valid),
        .out_re    (out_re),
        .out_im    (out_im)
    );

    typedef struct {
        real   er;
        real   ei;
        real   tol;
        string req;
    } exp_t;

    exp_t sb[$];
    int   checks   = 0;
    int   failures = 0;
    bit   done     = 1'b0;
    bit   have_last = 1'b0;
    int   last_re = 0;
    int   last_im = 0;

    localparam real PI = 3.14159265358979;

    function automatic real clampr(real v);
        if (v > 511.0)  return 511.0;
        if (v < -512.0) return -512.0;
        return v;
    endfunction

    function automatic real absr(real v);
        return (v < 0.0) ? -v : v;
    endfunction

    task automatic check(bit ok, string req, string what, int act, real expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%f", req, what, act, expv);
        end
    endtask

    task automatic send(int a, int b, int tw);
        exp_t e;
        real c8, s8, c4, xr, xi;
        c8 = $cos(PI / 8.0);
        s8 = $sin(PI / 8.0);
        c4 = $cos(PI / 4.0);
        e.tol = 3.0;
        case (tw)
            1: begin xr = c4 * (a + b);          xi = c4 * (b - a);          e.req = "R9"; end
            2: begin xr = b;                     xi = -a;                    e.req = "R5"; e.tol = 0.0; end
            3: begin xr = c4 * (b - a);          xi = -c4 * (a + b);         e.req = "R10"; end
            4: begin xr = a * c8 + b * s8;       xi = b * c8 - a * s8;       e.req = "R6"; end
            5: begin xr = a * s8 + b * c8;       xi = b * s8 - a * c8;       e.req = "R7"; end
            6: begin xr = -(a * c8 + b * s8);    xi = -(b * c8 - a * s8);    e.req = "R8"; end
            default: begin xr = a;               xi = b;                     e.req = "R4"; e.tol = 0.0; end
        endcase
        if (xr > 511.0 || xr < -512.0 || xi > 511.0 || xi < -512.0)
            e.req = {e.req, "/R11"};
        e.er = clampr(xr);
        e.ei = clampr(xi);
        @(negedge clk);
        in_valid = 1'b1;
        in_re    = a[9:0];
        in_im    = b[9:0];
        in_tw    = tw[2:0];
        sb.push_back(e);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_re    = 10'sd77;
            in_im    = -10'sd123;
            in_tw    = 3'd4;
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2", "unexpected out_valid", 1, 0.0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(absr(real'(int'(out_re)) - e.er) <= e.tol, e.req, "out_re", int'(out_re), e.er);
                    check(absr(real'(int'(out_im)) - e.ei) <= e.tol, e.req, "out_im", int'(out_im), e.ei);
                end
                have_last = 1'b1;
                last_re   = int'(out_re);
                last_im   = int'(out_im);
            end else if (have_last) begin
                // R3: held output during idle cycles
                check(int'(out_re) == last_re, "R3", "held out_re", int'(out_re), real'(last_re));
                check(int'(out_im) == last_im, "R3", "held out_im", int'(out_im), real'(last_im));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int corner_a[8];
        int corner_b[8];
        corner_a = '{-512, 511, 511, -512, 0, 1, 0, 300};
        corner_b = '{-512, 511, -512, 511, 0, 0, -1, -200};

        // drive junk during reset to confirm it is ignored
        in_valid = 1'b1;
        in_re    = 10'sd200;
        in_im    = 10'sd100;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0.0);
        check(out_re == 10'sd0, "R1", "out_re in reset", int'(out_re), 0.0);
        check(out_im == 10'sd0, "R1", "out_im in reset", int'(out_im), 0.0);
        in_valid = 1'b0;
        rst = 1'b0;
        idle(2);
        check(out_valid == 1'b0, "R2", "out_valid after reset with idle input", int'(out_valid), 0.0);

        // corner points on every code, back to back
        for (int tw = 0; tw < 8; tw++) begin
            for (int k = 0; k < 8; k++) send(corner_a[k], corner_b[k], tw);
        end
        idle(3);

        // random samples with idle gaps
        for (int n = 0; n < 400; n++) begin
            int a, b, tw;
            a  = int'($urandom_range(1023)) - 512;
            b  = int'($urandom_range(1023)) - 512;
            tw = int'($urandom_range(7));
            send(a, b, tw);
            if ((n % 37) == 5) idle(2);
        end
        idle(3);

        // R2: every accepted sample produced exactly one output
        check(sb.size() == 0, "R2", "scoreboard left over", sb.size(), 0.0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule